// File: doc/BRIEF.md
# Pipelined Two-Port Memory Interface

This block sits between a microcoded data path and a small behavioural memory. It holds the data path's memory-facing registers: a word address register, a data register, a program counter and a fetched-byte register, each loaded from the data path's result bus. Data reads and writes address memory in 32-bit words. The word address is scaled by four to form a byte address. Instruction fetches use the program counter directly as a byte address and return one byte.

Every request is pipelined with a fixed latency. A read or fetch issued in cycle k shows its result from cycle k+2. During cycle k+1 the destination register still holds its old value. A new request may be issued in every cycle, so requests in cycles k and k+1 deliver in cycles k+2 and k+3. A data read and a fetch may be issued in the same cycle, and each completes on its own. Each request samples the register values as they stand at the end of its issue cycle, so a register load and a request that uses it can share one cycle.

Top module: `dp_mem_port`

## Requirements
- R1: After reset, adr_o, dat_o, pc_o and ibyte_o are zero and every memory word reads as zero.
- R2: adr_ld_i, dat_ld_i and pc_ld_i load res_i into their register, visible in the next cycle. A register whose load input is low keeps its value.
- R3: A read issued in cycle k leaves dat_o unchanged in cycle k+1 and shows the addressed word in cycle k+2. dat_o changes only through a read or a dat_ld_i load.
- R4: Reads issued in consecutive cycles k and k+1 deliver their words in cycles k+2 and k+3 respectively.
- R5: A request uses the register values at the end of its issue cycle. A read issued together with adr_ld_i uses the newly loaded address.
- R6: A write issued in cycle k stores the data register value from the end of cycle k into the word addressed by the address register. A read issued in cycle k+1 or later returns the stored word.
- R7: A read and a write to the same word issued in the same cycle return the word's contents from before the write.
- R8: A fetch issued in cycle k leaves ibyte_o unchanged in cycle k+1. In cycle k+2, ibyte_o holds byte lane pc[1:0] of word pc[11:2]. The memory is little-endian: lane 0 is word bits 7:0 and lane 3 is bits 31:24.
- R9: A read and a fetch issued in the same cycle both complete in cycle k+2 with their own results.
- R10: When a read completes at the same edge as a dat_ld_i load, the memory word is written to the data register and the bus value is dropped.
- R11: Only address register bits 9:0 select a data word, and only program counter bits 11:0 select a fetch byte. Higher bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_i | input | 32 | Data path result bus |
| adr_ld_i | input | 1 | Load word address register from res_i |
| dat_ld_i | input | 1 | Load data register from res_i |
| pc_ld_i | input | 1 | Load program counter from res_i |
| rd_i | input | 1 | Issue word read |
| wr_i | input | 1 | Issue word write |
| fetch_i | input | 1 | Issue byte fetch |
| adr_o | output | 32 | Word address register |
| dat_o | output | 32 | Data register |
| pc_o | output | 32 | Program counter |
| ibyte_o | output | 8 | Fetched byte register |

## Verification
Register loads are due one cycle after issue. Read and fetch results are due two cycles after issue. Write data becomes visible to a read issued one cycle after the write. Each check drives inputs just after a rising edge and samples outputs at the following falling edge. Every read and fetch is checked twice: in cycle k+1 for the unchanged old value, and in cycle k+2 for the new result. Back-to-back reads are sampled in both cycles k+2 and k+3.

// File: rtl/dp_mem_pkg.sv
package dp_mem_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic fetch;
  } mem_op_t;

endpackage

// File: rtl/dp_mem_req_stage.sv
module dp_mem_req_stage
  import dp_mem_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 10,
  parameter int BADDR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mem_op_t            op_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [BADDR_W-1:0] fbaddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output mem_op_t            op_o,
  output logic [IDX_W-1:0]   widx_o,
  output logic [BADDR_W-1:0] fbaddr_o,
  output logic [DATA_W-1:0]  wdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o     <= '0;
      widx_o   <= '0;
      fbaddr_o <= '0;
      wdata_o  <= '0;
    end else begin
      op_o     <= op_i;
      widx_o   <= widx_i;
      fbaddr_o <= fbaddr_i;
      wdata_o  <= wdata_i;
    end
  end

endmodule

// File: rtl/dp_mem_array.sv
module dp_mem_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  fidx_i,
  output logic [DATA_W-1:0] fdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  // reads see contents before a write committed at the same edge
  assign rdata_o = mem_q[ridx_i];
  assign fdata_o = mem_q[fidx_i];

endmodule

// File: rtl/dp_mem_lane_sel.sv
module dp_mem_lane_sel #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BYTE_W-1:0] lane_w [LANES];

  // little-endian: lane 0 is the least significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lane_w[sel_i];

endmodule

// File: rtl/dp_mem_port.sv
module dp_mem_port
  import dp_mem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int MEM_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              adr_ld_i,
  input  logic              dat_ld_i,
  input  logic              pc_ld_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              fetch_i,
  output logic [DATA_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [BYTE_W-1:0] ibyte_o
);

  localparam int LANES   = DATA_W / BYTE_W;
  localparam int SEL_W   = $clog2(LANES);
  localparam int BADDR_W = $clog2(MEM_BYTES);
  localparam int DEPTH   = MEM_BYTES / LANES;
  localparam int IDX_W   = BADDR_W - SEL_W;

  logic [DATA_W-1:0] adr_q, dat_q, pc_q;
  logic [BYTE_W-1:0] ibyte_q;
  logic [DATA_W-1:0] adr_d, dat_d, pc_d;

  // values at the end of the issue cycle, loads included
  assign adr_d = adr_ld_i ? res_i : adr_q;
  assign dat_d = dat_ld_i ? res_i : dat_q;
  assign pc_d  = pc_ld_i  ? res_i : pc_q;

  // word address scaled by four to a byte address
  logic [DATA_W+SEL_W-1:0] adr_bytes;
  logic [IDX_W-1:0]        widx_d;
  logic [BADDR_W-1:0]      fbaddr_d;
  logic                    unused_hi;

  assign adr_bytes = {adr_d, {SEL_W{1'b0}}};
  assign widx_d    = adr_bytes[BADDR_W-1:SEL_W];
  assign fbaddr_d  = pc_d[BADDR_W-1:0];
  assign unused_hi = ^{adr_bytes[DATA_W+SEL_W-1:BADDR_W], adr_bytes[SEL_W-1:0],
                       pc_d[DATA_W-1:BADDR_W]};

  mem_op_t op_d, op_q;
  assign op_d = '{rd: rd_i, wr: wr_i, fetch: fetch_i};

  logic [IDX_W-1:0]   widx_q;
  logic [BADDR_W-1:0] fbaddr_q;
  logic [DATA_W-1:0]  wdata_q;

  dp_mem_req_stage #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .BADDR_W(BADDR_W)
  ) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op_d),
    .widx_i  (widx_d),
    .fbaddr_i(fbaddr_d),
    .wdata_i (dat_d),
    .op_o    (op_q),
    .widx_o  (widx_q),
    .fbaddr_o(fbaddr_q),
    .wdata_o (wdata_q)
  );

  logic [DATA_W-1:0] rdata, fword;
  logic [BYTE_W-1:0] fbyte;

  dp_mem_array #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (op_q.wr),
    .widx_i (widx_q),
    .wdata_i(wdata_q),
    .ridx_i (widx_q),
    .rdata_o(rdata),
    .fidx_i (fbaddr_q[BADDR_W-1:SEL_W]),
    .fdata_o(fword)
  );

  dp_mem_lane_sel #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_lane (
    .word_i(fword),
    .sel_i (fbaddr_q[SEL_W-1:0]),
    .byte_o(fbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q   <= '0;
      dat_q   <= '0;
      pc_q    <= '0;
      ibyte_q <= '0;
    end else begin
      adr_q <= adr_d;
      pc_q  <= pc_d;
      // completing read overrides a bus load
      dat_q <= op_q.rd ? rdata : dat_d;
      if (op_q.fetch) ibyte_q <= fbyte;
    end
  end

  assign adr_o   = adr_q;
  assign dat_o   = dat_q;
  assign pc_o    = pc_q;
  assign ibyte_o = ibyte_q;

endmodule

// File: rtl/dp_mem_port_chk.sv
module dp_mem_port_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] res_i,
  input logic              adr_ld_i,
  input logic              dat_ld_i,
  input logic              pc_ld_i,
  input logic              rd_i,
  input logic              fetch_i,
  input logic [DATA_W-1:0] adr_o,
  input logic [DATA_W-1:0] dat_o,
  input logic [DATA_W-1:0] pc_o,
  input logic [BYTE_W-1:0] ibyte_o
);

  // cycles since reset release, saturating
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_adr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_ld_i |=> adr_o == $past(res_i));

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_ld_i |=> $stable(pc_o));

  assert_dat_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && dat_o != $past(dat_o)) |-> ($past(rd_i, 2) || $past(dat_ld_i)));

  assert_ibyte_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && ibyte_o != $past(ibyte_o)) |-> $past(fetch_i, 2));

  assert_dat_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && dat_ld_i && !$past(rd_i)) |=> dat_o == $past(res_i));

endmodule

bind dp_mem_port dp_mem_port_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/dp_mem_port_tb_top.sv
`timescale 1ns/1ps
module dp_mem_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] res = '0;
  logic        adr_ld = 1'b0, dat_ld = 1'b0, pc_ld = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, fetch = 1'b0;
  logic [31:0] adr, dat, pc;
  logic [7:0]  ibyte;

  always #5 clk = ~clk;

  dp_mem_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res),
    .adr_ld_i(adr_ld), .dat_ld_i(dat_ld), .pc_ld_i(pc_ld),
    .rd_i(rd), .wr_i(wr), .fetch_i(fetch),
    .adr_o(adr), .dat_o(dat), .pc_o(pc), .ibyte_o(ibyte)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // {word index[9:0], data[31:0]}
  localparam logic [41:0] VEC [6] = '{
    {10'h000, 32'h1122_3344},
    {10'h001, 32'hA5A5_0F0F},
    {10'h155, 32'hDEAD_BEEF},
    {10'h2AA, 32'h0000_0080},
    {10'h3FF, 32'hCAFE_F00D},
    {10'h0C3, 32'h8765_4321}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #1;
  endtask

  task automatic mid();
    @(negedge clk);
  endtask

  task automatic idle();
    {adr_ld, dat_ld, pc_ld, rd, wr, fetch} = '0;
  endtask

  task automatic write_word(input logic [31:0] a, input logic [31:0] d);
    go(); idle(); res = a; adr_ld = 1'b1;
    go(); idle(); res = d; dat_ld = 1'b1; wr = 1'b1;
    go(); idle();
  endtask

  // address load and read share the issue cycle (R5)
  task automatic read_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] old;
    go(); idle(); res = a; adr_ld = 1'b1; rd = 1'b1;
    mid(); old = dat;
    go(); idle();
    mid(); chk("R3 old data held in k+1", dat, old);
    go();
    mid(); chk(tag, dat, exp);
  endtask

  task automatic fetch_chk(input logic [31:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] old;
    go(); idle(); res = a; pc_ld = 1'b1; fetch = 1'b1;
    mid(); old = ibyte;
    go(); idle();
    mid(); chk("R8 old byte held in k+1", {24'h0, ibyte}, {24'h0, old});
    go();
    mid(); chk(tag, {24'h0, ibyte}, {24'h0, exp});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mid();
    chk("R1 adr reset", adr, 32'h0);
    chk("R1 dat reset", dat, 32'h0);
    chk("R1 pc reset", pc, 32'h0);
    chk("R1 ibyte reset", {24'h0, ibyte}, 32'h0);
    read_chk(32'h7, 32'h0, "R1 memory cleared");
    fetch_chk(32'h0000_0FFF, 8'h00, "R1 memory cleared fetch");

    // R2 register loads and holds
    go(); idle(); res = 32'h0000_1234; adr_ld = 1'b1;
    go(); idle(); res = 32'h0000_0ABC; pc_ld = 1'b1;
    mid(); chk("R2 adr load", adr, 32'h0000_1234);
    go(); idle(); res = 32'hFFFF_FFFF;
    mid(); chk("R2 pc load", pc, 32'h0000_0ABC);
    go();
    mid(); chk("R2 pc hold", pc, 32'h0000_0ABC);
    chk("R2 adr hold", adr, 32'h0000_1234);

    // table walk: R6 write/read, R8 little-endian byte lanes
    for (int i = 0; i < 6; i++) write_word({22'h0, VEC[i][41:32]}, VEC[i][31:0]);
    for (int i = 0; i < 6; i++) read_chk({22'h0, VEC[i][41:32]}, VEC[i][31:0], "R6 write then read");
    for (int i = 0; i < 6; i++)
      for (int l = 0; l < 4; l++)
        fetch_chk({20'h0, VEC[i][41:32], 2'(l)}, VEC[i][l*8 +: 8], "R8 fetch lane");

    // R6 read issued the cycle after a write
    go(); idle(); res = 32'h0000_0010; adr_ld = 1'b1;
    go(); idle(); res = 32'h5555_AAAA; dat_ld = 1'b1; wr = 1'b1;
    go(); idle(); rd = 1'b1;
    go(); idle();
    go(); mid(); chk("R6 read right after write", dat, 32'h5555_AAAA);

    // R4 back-to-back reads
    go(); idle(); res = 32'h0000_0001; adr_ld = 1'b1; rd = 1'b1;
    go(); res = 32'h0000_0155;
    go(); idle();
    mid(); chk("R4 first read at k+2", dat, 32'hA5A5_0F0F);
    go();
    mid(); chk("R4 second read at k+3", dat, 32'hDEAD_BEEF);

    // R7 same-cycle read and write to one word
    go(); idle(); res = 32'h0000_03FF; adr_ld = 1'b1;
    go(); idle(); res = 32'h1234_5678; dat_ld = 1'b1; wr = 1'b1; rd = 1'b1;
    go(); idle();
    go(); mid(); chk("R7 read sees prior word", dat, 32'hCAFE_F00D);
    read_chk(32'h0000_03FF, 32'h1234_5678, "R7 write landed");

    // R9 read and fetch in the same cycle
    go(); idle(); res = 32'h0000_0155; adr_ld = 1'b1;
    go(); idle(); res = 32'h0000_030E; pc_ld = 1'b1; rd = 1'b1; fetch = 1'b1;
    go(); idle();
    go(); mid();
    chk("R9 read result", dat, 32'hDEAD_BEEF);
    chk("R9 fetch result", {24'h0, ibyte}, 32'h0000_0065);

    // R10 read completion beats bus load
    go(); idle(); res = 32'h0000_0001; adr_ld = 1'b1; rd = 1'b1;
    go(); idle(); res = 32'h0BAD_0BAD; dat_ld = 1'b1;
    go(); idle();
    mid(); chk("R10 memory wins over bus load", dat, 32'hA5A5_0F0F);
    go(); idle(); res = 32'h0BAD_0BAD; dat_ld = 1'b1;
    go(); idle();
    mid(); chk("R2 dat load", dat, 32'h0BAD_0BAD);

    // R11 high address bits alias
    read_chk(32'hFFFF_FEAA, 32'h0000_0080, "R11 word index aliasing");
    fetch_chk(32'h8000_0557, 8'hDE, "R11 fetch address aliasing");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule